// File: doc/BRIEF.md
# Framed serial signal packet receiver

This block listens on a single asynchronous serial line and rebuilds a parameterised-width signal vector from a stream of bytes. Each byte carries seven payload bits in its low bits. Bit 7 works as a framing marker. A byte with bit 7 set opens a packet and carries the lowest seven vector bits. Bytes with bit 7 clear carry the following seven-bit groups, with the least significant group first. A packet is `ceil(VEC_W/7)` bytes long. For example, a 20-bit vector takes three bytes.

The rebuilt vector is held in a shadow register while the packet arrives. It is copied to the output in a single cycle only when the last byte has arrived, so logic downstream never sees a vector that is partly updated. Because bit 7 marks where a packet starts, the receiver finds packet boundaries again after noise, dropped bytes or a framing error without any extra protocol.

The design has three parts. A two-flop synchroniser feeds a byte receiver state machine with the states RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_BREAK. That receiver feeds a packet assembler state machine with the states ASM_HUNT and ASM_GATHER. The byte receiver moves as follows. RX_IDLE goes to RX_START when the line falls low. RX_START goes back to RX_IDLE if the line is high again at half a bit, and otherwise goes to RX_DATA. RX_DATA goes to RX_STOP after eight bits. RX_STOP goes to RX_IDLE when the stop bit is high, and to RX_BREAK when it is low. RX_BREAK goes to RX_IDLE once the line is high. The assembler moves as follows. ASM_HUNT goes to ASM_GATHER on a head byte. ASM_GATHER goes back to ASM_HUNT on the last group or on a framing error. ASM_GATHER stays in ASM_GATHER when a new head byte arrives, and starts the packet over.

Top module: `sigpkt_rx`

## Requirements
- R1: A received byte with bit 7 = 1 is a head byte, and its bits 6:0 become vector bits 6:0 of the new packet.
- R2: Bytes with bit 7 = 0 that follow a head byte carry vector bits [7k+6:7k] for k = 1, 2, ... in arrival order. A packet holds ceil(VEC_W/7) bytes, and group bits at positions VEC_W and above are discarded.
- R3: The serial frame is one low start bit, eight data bits sent LSB first, and one high stop bit, with no parity. Each bit lasts CLK_HZ/BAUD clock cycles and the line idles high.
- R4: `sig_vec` changes only in the cycle after the final byte of a packet is accepted, and it takes the whole new vector at once. At all other times it holds its value.
- R5: A head byte that arrives while a packet is partly received discards the partial data and starts a new packet.
- R6: A byte with bit 7 = 0 that arrives when no packet is in progress is ignored.
- R7: A byte whose stop bit is sampled low is discarded and drops any packet in progress. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: While reset is asserted, and after it is released, `sig_vec` is all zeros until the first complete packet.
- R9: The line passes through a two-flop synchroniser. A low pulse that is no longer high-to-high than half a bit period is rejected as a false start and produces no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| sig_vec | output | VEC_W | Rebuilt signal vector, updated once per complete packet |

## Verification
The hardest case to reach from the ports is a framing error in the middle of a packet. Here a continuation byte ends with a low stop bit, and the bytes that follow must then be ignored until a fresh head byte arrives. The bench drives this with its byte task, which can hold the stop bit low and then keep the line high for an extra bit time. It follows the bad byte with a stray continuation byte and then a clean packet. A restart in the middle of a packet and a start glitch shorter than half a bit are also built by hand. After each of these, the output must stay unchanged until the next complete packet.

// File: rtl/sigpkt_pkg.sv
package sigpkt_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_t;

    typedef enum logic {
        ASM_HUNT,
        ASM_GATHER
    } asm_state_t;

    localparam int GROUP_W = 7;

    function automatic int group_count(input int width);
        return (width + GROUP_W - 1) / GROUP_W;
    endfunction

endpackage

// File: rtl/sigpkt_sync.sv
module sigpkt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sigpkt_byte_rx.sv
module sigpkt_byte_rx
    import sigpkt_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    output logic       byte_vld,
    output logic       byte_err,
    output logic [7:0] byte_data
);
    localparam int BIT_CYC  = CLK_HZ / BAUD;
    localparam int HALF_CYC = BIT_CYC / 2;
    localparam int CW       = $clog2(BIT_CYC + 1);

    rx_state_t      state, nxt;
    logic [CW-1:0]  tick;
    logic [2:0]     bitn;
    logic [7:0]     shreg;
    logic           tick_end;

    always_comb begin
        if (state == RX_START) tick_end = (tick == CW'(HALF_CYC - 1));
        else                   tick_end = (tick == CW'(BIT_CYC - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= RX_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!rx_s) nxt = RX_START;
            RX_START: if (tick_end) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_end && bitn == 3'd7) nxt = RX_STOP;
            RX_STOP:  if (tick_end) nxt = rx_s ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (rx_s) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            tick      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_err  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            byte_err <= 1'b0;
            if (state == RX_IDLE || state == RX_BREAK || tick_end || state != nxt)
                tick <= '0;
            else
                tick <= tick + 1'b1;
            unique case (state)
                RX_START: bitn <= '0;
                RX_DATA: begin
                    if (tick_end) begin
                        shreg <= {rx_s, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick_end) begin
                        if (rx_s) begin
                            byte_vld  <= 1'b1;
                            byte_data <= shreg;
                        end else begin
                            byte_err <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sigpkt_assembler.sv
module sigpkt_assembler
    import sigpkt_pkg::*;
#(
    parameter int VEC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic             byte_err,
    input  logic [7:0]       byte_data,
    output logic [VEC_W-1:0] vec,
    output logic             busy
);
    localparam int NGRP  = group_count(VEC_W);
    localparam int ACC_W = NGRP * GROUP_W;
    localparam int IW    = (NGRP > 1) ? $clog2(NGRP) : 1;

    asm_state_t        state, nxt;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  merged;
    logic [ACC_W-1:0]  head_vec;
    logic [IW-1:0]     idx;
    logic              is_head;
    logic              is_last;

    assign is_head  = byte_vld && byte_data[7];
    assign is_last  = (int'(idx) == NGRP - 1);
    assign head_vec = ACC_W'(byte_data[6:0]);

    always_comb begin
        merged = acc;
        if (int'(idx) < NGRP)
            merged[int'(idx)*GROUP_W +: GROUP_W] = byte_data[6:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ASM_HUNT;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ASM_HUNT: if (is_head && NGRP > 1) nxt = ASM_GATHER;
            ASM_GATHER: begin
                if (byte_err)                 nxt = ASM_HUNT;
                else if (is_head)             nxt = ASM_GATHER;
                else if (byte_vld && is_last) nxt = ASM_HUNT;
            end
            default: nxt = ASM_HUNT;
        endcase
    end

    // outputs and shadow data
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            idx <= '0;
            vec <= '0;
        end else if (is_head) begin
            acc <= head_vec;
            idx <= IW'(1);
            if (NGRP == 1) vec <= head_vec[VEC_W-1:0];
        end else if (state == ASM_GATHER && byte_vld) begin
            acc <= merged;
            idx <= idx + 1'b1;
            if (is_last) vec <= merged[VEC_W-1:0];
        end
    end

    assign busy = (state == ASM_GATHER);
endmodule

// File: rtl/sigpkt_rx.sv
module sigpkt_rx
    import sigpkt_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200,
    parameter int VEC_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    output logic [VEC_W-1:0] sig_vec
);
    localparam int NGRP = group_count(VEC_W);

    logic       rx_s;
    logic       byte_vld;
    logic       byte_err;
    logic [7:0] byte_data;
    logic       busy;

    sigpkt_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (rx_s)
    );

    sigpkt_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_byte (
        .clk       (clk),
        .rst       (rst),
        .rx_s      (rx_s),
        .byte_vld  (byte_vld),
        .byte_err  (byte_err),
        .byte_data (byte_data)
    );

    sigpkt_assembler #(.VEC_W(VEC_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_err  (byte_err),
        .byte_data (byte_data),
        .vec       (sig_vec),
        .busy      (busy)
    );
endmodule

// File: rtl/sigpkt_rx_chk.sv
module sigpkt_rx_chk #(
    parameter int VEC_W = 20,
    parameter int NGRP  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [VEC_W-1:0] sig_vec,
    input logic             byte_vld,
    input logic             byte_err,
    input logic [7:0]       byte_data,
    input logic             busy
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> sig_vec == '0); // R8
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) !byte_vld |=> $stable(sig_vec)); // R4
    AST_FRAME_DROP: assert property (@(posedge clk) disable iff (rst) byte_err |=> (!busy && $stable(sig_vec))); // R7
    AST_EXCLUSIVE_EVENTS: assert property (@(posedge clk) disable iff (rst) !(byte_vld && byte_err)); // R3
    AST_SPACED_BYTES: assert property (@(posedge clk) disable iff (rst) byte_vld |=> !byte_vld); // R3
    AST_HEAD_OPENS: assert property (@(posedge clk) disable iff (rst) (byte_vld && byte_data[7]) |=> (NGRP == 1 || busy)); // R5
endmodule

bind sigpkt_rx sigpkt_rx_chk #(.VEC_W(VEC_W), .NGRP(NGRP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_vec   (sig_vec),
    .byte_vld  (byte_vld),
    .byte_err  (byte_err),
    .byte_data (byte_data),
    .busy      (busy)
);

// File: tb/sigpkt_rx_bench.sv
module sigpkt_rx_bench;
    localparam int CLK_HZ = 50_000_000;
    localparam int BAUD   = 2_500_000;
    localparam int W      = 20;
    localparam int BITC   = CLK_HZ / BAUD;
    localparam int NG     = (W + 6) / 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_line = 1'b1;
    logic [W-1:0] sig_vec;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_seen = '0;

    always #10 clk = ~clk;

    sigpkt_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .VEC_W(W)) u_sigpkt_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_line (rx_line),
        .sig_vec (sig_vec)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: every change on the output must match the next queued vector
    always @(negedge clk) begin
        if (!rst && !done && sig_vec !== last_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected output change", sig_vec, last_seen);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(sig_vec === e, "R1 R2 packet value", sig_vec, e);
            end
            last_seen = sig_vec;
        end
    end

    task automatic wait_bits(input int n);
        repeat (n * BITC) @(negedge clk);
    endtask

    // R3: start, 8 data bits LSB first, stop
    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        rx_line = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_bits(1);
        end
        rx_line = good_stop;
        wait_bits(1);
        rx_line = 1'b1;
        wait_bits(good_stop ? 1 : 2);
    endtask

    task automatic send_packet(input logic [W-1:0] v);
        logic [NG*7-1:0] ext;
        ext = (NG*7)'(v);
        exp_q.push_back(v);
        for (int g = 0; g < NG; g++)
            send_byte({(g == 0), ext[g*7 +: 7]}, 1'b1);
    endtask

    task automatic expect_hold(input string tag);
        check(exp_q.size() == 0 && sig_vec === last_seen, tag, sig_vec, last_seen);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(sig_vec === '0, "R8 reset value", sig_vec, '0);
        rst = 1'b0;
        wait_bits(2);
        check(sig_vec === '0, "R8 after reset release", sig_vec, '0);

        // R1 R2 R3 basic packets
        send_packet(20'hABCDE);
        send_packet(20'h00001);
        send_packet(20'hFFFFF);
        send_packet(20'h80000);
        check(exp_q.size() == 0, "R3 all packets delivered", W'(exp_q.size()), '0);

        // R2: group bits above the vector width are dropped -> 0xFD111
        exp_q.push_back(20'hFD111);
        send_byte(8'h91, 1'b1);
        send_byte(8'h22, 1'b1);
        send_byte(8'h7F, 1'b1);
        check(sig_vec === 20'hFD111, "R2 excess bits dropped", sig_vec, 20'hFD111);

        // R6: orphan continuation bytes ignored
        send_byte(8'h15, 1'b1);
        send_byte(8'h2A, 1'b1);
        send_byte(8'h7F, 1'b1);
        expect_hold("R6 orphan bytes ignored");

        // R4: output unchanged until last byte
        exp_q.push_back(20'h3C0F1);
        send_byte(8'h80 | 8'h71, 1'b1);
        send_byte(8'h01, 1'b1);
        check(sig_vec === 20'hFD111, "R4 partial packet not visible", sig_vec, 20'hFD111);
        send_byte(8'h0F, 1'b1);
        check(sig_vec === 20'h3C0F1, "R4 atomic update", sig_vec, 20'h3C0F1);

        // R5: head byte mid-packet restarts
        send_byte(8'h81, 1'b1);
        send_byte(8'h05, 1'b1);
        send_packet(20'h12345);
        check(sig_vec === 20'h12345, "R5 restart on head", sig_vec, 20'h12345);

        // R7: framing error drops packet, trailing continuation ignored
        send_byte(8'hAA, 1'b1);
        send_byte(8'h33, 1'b0);
        send_byte(8'h0C, 1'b1);
        expect_hold("R7 framing error drops packet");
        send_packet(20'h0BEEF);
        check(sig_vec === 20'h0BEEF, "R7 recovery after error", sig_vec, 20'h0BEEF);

        // R9: short low glitch rejected
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        wait_bits(2);
        expect_hold("R9 glitch rejected");
        send_packet(20'h55AA5);
        check(sig_vec === 20'h55AA5, "R9 packet after glitch", sig_vec, 20'h55AA5);

        wait_bits(2);
        check(exp_q.size() == 0, "R4 scoreboard drained", W'(exp_q.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R3 actual=%h expected=%h", sig_vec, last_seen);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule